// File: doc/BRIEF.md
# Quad Wiper Serial Command Controller

This block is the digital core of a four-channel digitally controlled potentiometer. A host talks to it over a serial bus. Each transfer is framed by an active-low chip select, and the clock and data lines are sampled by the block's own system clock. A transfer opens with an addressing byte. It carries a fixed device-type nibble and a two-bit hardware address that must match the strapped `dev_addr` pins, so up to four parts can share one bus. A command byte follows. It names an operation, one of four storage registers and one of four pots.

Each pot holds an 8-bit wiper code and four 8-bit storage registers. The wiper codes drive the resistor-array decoders through `wiper_codes`. Code 00h selects the low terminal and FFh selects the high terminal. The host can do the following:
- write or read a wiper code;
- write or read a storage register;
- copy in either direction between a storage register and the wiper;
- step the wiper up or down one position per serial clock;
- read a status byte.

Any change to a storage register arms a save to non-volatile cells. The save starts when chip select is released and takes a fixed number of clocks. A write-in-progress flag is set for that time and can be read through the status command.

Top module: `quad_wiper_ctrl`

## Requirements
- R1: The first byte of a frame is accepted only if bits 7:4 are 0101, bits 3:2 are 00 and bits 1:0 equal `dev_addr`. Otherwise every later bit of that frame is ignored, and no register changes until `cs_n` has gone high.
- R2: In the second byte, bits 7:4 are the opcode, bits 3:2 select storage register 0..3 and bits 1:0 select pot 0..3. Pot p drives `wiper_codes[8p+7:8p]`.
- R3: Opcode 1010 followed by a full data byte loads the selected pot's wiper code, which appears on `wiper_codes`.
- R4: Opcodes 1001 (read wiper), 1011 (read storage register) and 0101 (read status) return one byte on `sdo`, MSB first. Each new bit is presented after a falling edge of `sck`. `sdo_oe` is high only during that return phase while `cs_n` is low, and it is low whenever `cs_n` is high.
- R5: Opcode 1100 followed by a full data byte stores the byte in the selected storage register.
- R6: Opcode 1101 copies the selected storage register into the pot's wiper code, and opcode 1110 copies the wiper code into the selected storage register. Both take effect as soon as the command byte is complete.
- R7: After opcode 0010, each rising `sck` edge while `cs_n` is low steps the selected wiper code: up when `sdi` is 1, down when `sdi` is 0. The code holds at FFh and at 00h and never wraps.
- R8: A save starts when `cs_n` rises after a frame in which a storage register was changed by a complete 1100 data byte or by a 1110 copy. An unfinished data byte or a wiper-only command starts no save. A save keeps the busy flag set for NV_BUSY_CYCLES clocks.
- R9: The status byte returns the busy flag in bit 0 and zeros in bits 7:1.
- R10: While the busy flag is set, every opcode other than 0101 is ignored for the rest of its frame.
- R11: Opcodes outside the eight listed are ignored, and no register changes.
- R12: After reset, all wiper codes and storage registers are 00h, the busy flag is clear and `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial bus clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host, MSB first |
| dev_addr | input | 2 | Strapped hardware address |
| sdo | output | 1 | Serial return data |
| sdo_oe | output | 1 | Output enable for `sdo` (low means high impedance) |
| wiper_codes | output | 32 | Four 8-bit wiper codes, pot 0 in the low byte |

## Verification
A wiper code or storage register that is wrong shows up on `wiper_codes` a few clocks after the data byte that sets it. For a storage register, it shows up in the next read frame. A decoder that acts on a rejected addressing byte, an unknown opcode or a command sent while busy changes a register that the bench then observes. A timer that starts too early, starts on an incomplete write or never clears is seen in bit 0 of the next status read. A stepping error at either end shows as a wiped-around code right after the extra clock edge.

// File: rtl/qwc_pkg.sv
// Shared constants and types for the quad wiper serial command controller.
// Assumes an 8-bit wiper/storage width and 2-bit pot and register selectors.
package qwc_pkg;
    localparam int CODE_W  = 8;
    localparam int SEL_W   = 2;
    localparam int N_POTS  = 1 << SEL_W;
    localparam int N_REGS  = 1 << SEL_W;
    localparam int BITCNT_W = $clog2(CODE_W);
    localparam logic [3:0] DEV_TYPE = 4'b0101;

    typedef enum logic [3:0] {
        OP_STEP    = 4'b0010,
        OP_STATUS  = 4'b0101,
        OP_RD_WIPE = 4'b1001,
        OP_WR_WIPE = 4'b1010,
        OP_RD_STOR = 4'b1011,
        OP_WR_STOR = 4'b1100,
        OP_S2W     = 4'b1101,
        OP_W2S     = 4'b1110
    } opcode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_STEP, ST_READ, ST_SKIP
    } state_e;
endpackage

// File: rtl/qwc_serial_rx.sv
// Serial front end: brings sck, cs_n and sdi into the clk domain through two
// flops each, finds edges and assembles bytes MSB first on rising sck edges.
// Assumes each sck phase lasts at least four clk periods.
module qwc_serial_rx
    import qwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              cs_active,
    output logic              cs_start,
    output logic              cs_stop,
    output logic              sck_rise,
    output logic              sck_fall,
    output logic              rx_bit,
    output logic              byte_done,
    output logic [CODE_W-1:0] rx_byte
);
    logic [1:0]          sck_s, cs_s, sdi_s;
    logic                sck_d, cs_d;
    logic [CODE_W-2:0]   shreg;
    logic [BITCNT_W-1:0] bit_cnt;

    // Two-flop synchronizers plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s <= 2'b00;
            cs_s  <= 2'b11;
            sdi_s <= 2'b00;
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_s <= {sck_s[0], sck};
            cs_s  <= {cs_s[0], cs_n};
            sdi_s <= {sdi_s[0], sdi};
            sck_d <= sck_s[1];
            cs_d  <= cs_s[1];
        end
    end

    assign cs_active = ~cs_s[1];
    assign cs_start  = cs_d & ~cs_s[1];
    assign cs_stop   = ~cs_d & cs_s[1];
    assign sck_rise  = cs_active & sck_s[1] & ~sck_d;
    assign sck_fall  = cs_active & ~sck_s[1] & sck_d;
    assign rx_bit    = sdi_s[1];

    // Bit counter and shifter, restarted at every frame opening.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (cs_start) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            shreg   <= {shreg[CODE_W-3:0], rx_bit};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign byte_done = sck_rise && (bit_cnt == BITCNT_W'(CODE_W - 1));
    assign rx_byte   = {shreg, rx_bit};
endmodule

// File: rtl/qwc_cmd_fsm.sv
// Frame sequencer: checks the addressing byte, decodes the command byte,
// issues one-cycle register strobes and shifts read data out on falling sck.
// Assumes the busy flag can only rise at a frame close.
module qwc_cmd_fsm
    import qwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  dev_addr,
    input  logic              cs_active,
    input  logic              cs_start,
    input  logic              cs_stop,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              rx_bit,
    input  logic              byte_done,
    input  logic [CODE_W-1:0] rx_byte,
    input  logic              busy,
    input  logic [CODE_W-1:0] rd_wiper,
    input  logic [CODE_W-1:0] rd_stor,
    output logic [SEL_W-1:0]  sel_pot,
    output logic [SEL_W-1:0]  sel_reg,
    output logic              wr_wiper,
    output logic              wr_stor,
    output logic              ld_s2w,
    output logic              ld_w2s,
    output logic              step_en,
    output logic              step_up,
    output logic              save_arm,
    output logic              sdo,
    output logic              sdo_oe,
    output state_e            state
);
    opcode_e          op_q, rx_op;
    logic [SEL_W-1:0] pot_q, reg_q;
    logic [CODE_W-1:0] tx_sh;
    logic             addr_ok, op_known, cmd_ok, in_cmd;
    state_e           accept_next;

    assign rx_op   = opcode_e'(rx_byte[7:4]);
    assign addr_ok = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:2] == 2'b00)
                     && (rx_byte[1:0] == dev_addr);
    assign in_cmd  = (state == ST_CMD) && byte_done;

    // Classify the incoming opcode and choose the phase it leads to.
    always_comb begin
        op_known    = 1'b1;
        accept_next = ST_SKIP;
        case (rx_op)
            OP_RD_WIPE, OP_RD_STOR, OP_STATUS: accept_next = ST_READ;
            OP_WR_WIPE, OP_WR_STOR:            accept_next = ST_WDATA;
            OP_STEP:                           accept_next = ST_STEP;
            OP_S2W, OP_W2S:                    accept_next = ST_SKIP;
            default:                           op_known    = 1'b0;
        endcase
    end
    assign cmd_ok = op_known && (!busy || rx_op == OP_STATUS);

    // Frame phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (cs_start) begin
            state <= ST_ADDR;
        end else if (cs_stop) begin
            state <= ST_IDLE;
        end else if (byte_done) begin
            case (state)
                ST_ADDR:  state <= addr_ok ? ST_CMD : ST_SKIP;
                ST_CMD:   state <= cmd_ok ? accept_next : ST_SKIP;
                ST_WDATA: state <= ST_SKIP;
                default:  state <= state;
            endcase
        end
    end

    // Latch the command fields once the command byte is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= OP_STATUS;
            pot_q <= '0;
            reg_q <= '0;
        end else if (in_cmd) begin
            op_q  <= rx_op;
            pot_q <= rx_byte[1:0];
            reg_q <= rx_byte[3:2];
        end
    end

    // Selectors follow the live command byte during its last bit.
    assign sel_pot = (state == ST_CMD) ? rx_byte[1:0] : pot_q;
    assign sel_reg = (state == ST_CMD) ? rx_byte[3:2] : reg_q;

    // One-cycle strobes towards the register bank and the save timer.
    assign wr_wiper = (state == ST_WDATA) && byte_done && (op_q == OP_WR_WIPE);
    assign wr_stor  = (state == ST_WDATA) && byte_done && (op_q == OP_WR_STOR);
    assign ld_s2w   = in_cmd && cmd_ok && (rx_op == OP_S2W);
    assign ld_w2s   = in_cmd && cmd_ok && (rx_op == OP_W2S);
    assign step_en  = (state == ST_STEP) && sck_rise;
    assign step_up  = rx_bit;
    assign save_arm = wr_stor || ld_w2s;

    // Return shifter: loaded at command end, one bit per falling sck.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            sdo   <= 1'b0;
        end else if (cs_start) begin
            sdo   <= 1'b0;
        end else if (in_cmd && cmd_ok) begin
            case (rx_op)
                OP_RD_WIPE: tx_sh <= rd_wiper;
                OP_RD_STOR: tx_sh <= rd_stor;
                default:    tx_sh <= {{(CODE_W-1){1'b0}}, busy};
            endcase
        end else if (sck_fall && state == ST_READ) begin
            sdo   <= tx_sh[CODE_W-1];
            tx_sh <= {tx_sh[CODE_W-2:0], 1'b0};
        end
    end

    assign sdo_oe = cs_active && (state == ST_READ);
endmodule

// File: rtl/qwc_pot_bank.sv
// Per-pot wiper code and storage registers with load, copy and saturating
// step. Assumes at most one strobe per cycle from the sequencer.
module qwc_pot_bank
    import qwc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SEL_W-1:0]         sel_pot,
    input  logic [SEL_W-1:0]         sel_reg,
    input  logic [CODE_W-1:0]        wdata,
    input  logic                     wr_wiper,
    input  logic                     wr_stor,
    input  logic                     ld_s2w,
    input  logic                     ld_w2s,
    input  logic                     step_en,
    input  logic                     step_up,
    output logic [CODE_W-1:0]        rd_wiper,
    output logic [CODE_W-1:0]        rd_stor,
    output logic [N_POTS*CODE_W-1:0] wiper_codes
);
    localparam int STOR_BITS = N_POTS * N_REGS * CODE_W;
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [STOR_BITS-1:0] stor_flat;

    for (genvar p = 0; p < N_POTS; p++) begin : g_pot
        logic              hit;
        logic [CODE_W-1:0] wiper_r, own_stor;

        assign hit      = (sel_pot == SEL_W'(p));
        assign own_stor = stor_flat[(p*N_REGS + int'(sel_reg))*CODE_W +: CODE_W];

        // Wiper code update: load, copy in, or step with end stops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wiper_r <= '0;
            end else if (hit && wr_wiper) begin
                wiper_r <= wdata;
            end else if (hit && ld_s2w) begin
                wiper_r <= own_stor;
            end else if (hit && step_en) begin
                if (step_up && wiper_r != CODE_MAX)
                    wiper_r <= wiper_r + 1'b1;
                else if (!step_up && wiper_r != '0)
                    wiper_r <= wiper_r - 1'b1;
            end
        end
        assign wiper_codes[p*CODE_W +: CODE_W] = wiper_r;

        for (genvar r = 0; r < N_REGS; r++) begin : g_reg
            logic stor_r_hit;
            logic [CODE_W-1:0] stor_r;
            assign stor_r_hit = hit && (sel_reg == SEL_W'(r));

            // Storage register update from a data byte or the wiper.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stor_r <= '0;
                else if (stor_r_hit && wr_stor)
                    stor_r <= wdata;
                else if (stor_r_hit && ld_w2s)
                    stor_r <= wiper_r;
            end
            assign stor_flat[(p*N_REGS + r)*CODE_W +: CODE_W] = stor_r;
        end
    end

    assign rd_wiper = wiper_codes[int'(sel_pot)*CODE_W +: CODE_W];
    assign rd_stor  = stor_flat[(int'(sel_pot)*N_REGS + int'(sel_reg))*CODE_W +: CODE_W];
endmodule

// File: rtl/qwc_save_timer.sv
// Models the non-volatile save: arms on a storage change and runs a fixed
// busy count once the frame closes. Assumes arm pulses only inside frames.
module qwc_save_timer #(
    parameter int NV_BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic save_arm,
    input  logic cs_stop,
    output logic busy
);
    localparam int CNT_W = $clog2(NV_BUSY_CYCLES + 1);

    logic             armed;
    logic [CNT_W-1:0] cnt;

    // Arm during the frame, start at its close, count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (cs_stop) begin
            armed <= 1'b0;
            if (armed) cnt <= CNT_W'(NV_BUSY_CYCLES);
        end else begin
            if (save_arm) armed <= 1'b1;
            if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/quad_wiper_ctrl.sv
// Top level of the quad wiper serial command controller: serial front end,
// frame sequencer, pot register bank and save timer.
// Assumes clk runs at least eight times faster than sck.
module quad_wiper_ctrl
    import qwc_pkg::*;
#(
    parameter int NV_BUSY_CYCLES = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sck,
    input  logic                     cs_n,
    input  logic                     sdi,
    input  logic [SEL_W-1:0]         dev_addr,
    output logic                     sdo,
    output logic                     sdo_oe,
    output logic [N_POTS*CODE_W-1:0] wiper_codes
);
    logic              cs_active, cs_start, cs_stop, sck_rise, sck_fall;
    logic              rx_bit, byte_done, busy;
    logic [CODE_W-1:0] rx_byte, rd_wiper, rd_stor;
    logic [SEL_W-1:0]  sel_pot, sel_reg;
    logic              wr_wiper, wr_stor, ld_s2w, ld_w2s, step_en, step_up, save_arm;
    state_e            state;

    qwc_serial_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
        .cs_active(cs_active), .cs_start(cs_start), .cs_stop(cs_stop),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .rx_bit(rx_bit),
        .byte_done(byte_done), .rx_byte(rx_byte)
    );

    qwc_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr),
        .cs_active(cs_active), .cs_start(cs_start), .cs_stop(cs_stop),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .rx_bit(rx_bit),
        .byte_done(byte_done), .rx_byte(rx_byte), .busy(busy),
        .rd_wiper(rd_wiper), .rd_stor(rd_stor),
        .sel_pot(sel_pot), .sel_reg(sel_reg),
        .wr_wiper(wr_wiper), .wr_stor(wr_stor), .ld_s2w(ld_s2w), .ld_w2s(ld_w2s),
        .step_en(step_en), .step_up(step_up), .save_arm(save_arm),
        .sdo(sdo), .sdo_oe(sdo_oe), .state(state)
    );

    qwc_pot_bank u_bank (
        .clk(clk), .rst_n(rst_n), .sel_pot(sel_pot), .sel_reg(sel_reg),
        .wdata(rx_byte), .wr_wiper(wr_wiper), .wr_stor(wr_stor),
        .ld_s2w(ld_s2w), .ld_w2s(ld_w2s), .step_en(step_en), .step_up(step_up),
        .rd_wiper(rd_wiper), .rd_stor(rd_stor), .wiper_codes(wiper_codes)
    );

    qwc_save_timer #(.NV_BUSY_CYCLES(NV_BUSY_CYCLES)) u_save (
        .clk(clk), .rst_n(rst_n), .save_arm(save_arm), .cs_stop(cs_stop),
        .busy(busy)
    );
endmodule

// File: rtl/qwc_checker.sv
// Property checker for quad_wiper_ctrl, attached through bind below.
// Assumes it observes the top's internal strobes and busy flag.
module qwc_checker
    import qwc_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_n,
    input logic                     sdo_oe,
    input logic                     busy,
    input logic                     cs_stop,
    input logic                     step_en,
    input logic                     step_up,
    input logic [SEL_W-1:0]         sel_pot,
    input logic [4:0]               strobes,
    input logic [N_POTS*CODE_W-1:0] wiper_codes
);
    logic [CODE_W-1:0] cur_code;
    assign cur_code = wiper_codes[int'(sel_pot)*CODE_W +: CODE_W];

    assert_oe_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !sdo_oe);

    assert_save_at_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_stop));

    assert_top_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && cur_code == '1) |=> (cur_code == '1));

    assert_bottom_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && cur_code == '0) |=> (cur_code == '0));

    assert_busy_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (strobes == 5'b0));

    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));
endmodule

bind quad_wiper_ctrl qwc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_oe(sdo_oe), .busy(busy),
    .cs_stop(cs_stop), .step_en(step_en), .step_up(step_up), .sel_pot(sel_pot),
    .strobes({wr_wiper, wr_stor, ld_s2w, ld_w2s, step_en}),
    .wiper_codes(wiper_codes)
);

// File: tb/tb_quad_wiper_ctrl.sv
module tb_quad_wiper_ctrl;
    localparam int BUSY = 2000;
    localparam int HALF = 6;
    localparam logic [7:0] ADDR_BYTE = 8'h52;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] data;
        logic       has_data;
        logic       saves;
        logic [7:0] rd_cmd;
        logic [7:0] expect_v;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{8'hA1, 8'h3C, 1'b1, 1'b0, 8'h91, 8'h3C, 4'd3},   // R3 wiper write pot1
        '{8'hCE, 8'hA5, 1'b1, 1'b1, 8'hBE, 8'hA5, 4'd5},   // R5 storage p2 r3
        '{8'hC4, 8'h5A, 1'b1, 1'b1, 8'hB4, 8'h5A, 4'd2},   // R2 field split p0 r1
        '{8'hDE, 8'h00, 1'b0, 1'b0, 8'h92, 8'hA5, 4'd6},   // R6 storage to wiper
        '{8'hA3, 8'h77, 1'b1, 1'b0, 8'h93, 8'h77, 4'd4},   // R4 read back pot3
        '{8'hEB, 8'h00, 1'b0, 1'b1, 8'hBB, 8'h77, 4'd6},   // R6 wiper to storage
        '{8'hF1, 8'h00, 1'b0, 1'b0, 8'h91, 8'h3C, 4'd11},  // R11 unknown opcode
        '{8'hA0, 8'hFF, 1'b1, 1'b0, 8'h90, 8'hFF, 4'd3}    // R3 full scale
    };

    logic        clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic [1:0]  dev_addr = 2'b10;
    logic        sdo, sdo_oe;
    logic [31:0] wiper_codes;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    quad_wiper_ctrl #(.NV_BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
        .dev_addr(dev_addr), .sdo(sdo), .sdo_oe(sdo_oe), .wiper_codes(wiper_codes)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_open();
        @(negedge clk); cs_n = 1'b0; wait_clk(HALF);
    endtask

    task automatic frame_close();
        wait_clk(HALF); cs_n = 1'b1; sdi = 1'b0; wait_clk(2 * HALF);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sdi = v[i]; wait_clk(HALF);
            sck = 1'b1; wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic get_byte(output logic [7:0] v, output logic oe);
        oe = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sdi = 1'b0; wait_clk(HALF);
            v[i] = sdo;
            oe = oe & sdo_oe;
            sck = 1'b1; wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic write_frame(input logic [7:0] a, input logic [7:0] c,
                               input logic [7:0] d, input bit with_data);
        frame_open();
        send_bits(a, 8); send_bits(c, 8);
        if (with_data) send_bits(d, 8);
        frame_close();
    endtask

    task automatic read_frame(input logic [7:0] c, output logic [7:0] v, output logic oe);
        frame_open();
        send_bits(ADDR_BYTE, 8); send_bits(c, 8);
        get_byte(v, oe);
        frame_close();
    endtask

    task automatic step_frame(input logic [1:0] pot, input logic [7:0] dirs, input int n);
        frame_open();
        send_bits(ADDR_BYTE, 8); send_bits({6'b001000, pot}, 8);
        send_bits(dirs, n);
        frame_close();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rv;
        logic       oe;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        check("R12 wiper codes after reset", wiper_codes, 32'h0);
        check("R12 sdo_oe after reset", {31'b0, sdo_oe}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            write_frame(ADDR_BYTE, VEC[k].cmd, VEC[k].data, VEC[k].has_data);
            if (VEC[k].saves) wait_clk(BUSY + 100);
            read_frame(VEC[k].rd_cmd, rv, oe);
            checks++;
            if (rv !== VEC[k].expect_v) begin
                fails++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h",
                         VEC[k].req, k, rv, VEC[k].expect_v);
            end
        end

        check("R2 R3 wiper_codes map", wiper_codes, 32'h77A53CFF);
        read_frame(8'h93, rv, oe);
        check("R4 sdo_oe high in return phase", {31'b0, oe}, 32'h1);
        check("R4 sdo_oe low when deselected", {31'b0, sdo_oe}, 32'h0);

        // R1: wrong device type, wrong address, nonzero reserved bits
        write_frame(8'h62, 8'hA1, 8'h99, 1'b1);
        check("R1 bad type ignored", {24'b0, wiper_codes[15:8]}, 32'h3C);
        write_frame(8'h51, 8'hA1, 8'h99, 1'b1);
        check("R1 bad address ignored", {24'b0, wiper_codes[15:8]}, 32'h3C);
        write_frame(8'h5A, 8'hA1, 8'h99, 1'b1);
        check("R1 reserved bits ignored", {24'b0, wiper_codes[15:8]}, 32'h3C);

        // R7: stepping with end stops
        write_frame(ADDR_BYTE, 8'hA1, 8'hFD, 1'b1);
        step_frame(2'd1, 8'hF0, 4);
        check("R7 step up stops at FF", {24'b0, wiper_codes[15:8]}, 32'hFF);
        step_frame(2'd1, 8'h00, 3);
        check("R7 step down", {24'b0, wiper_codes[15:8]}, 32'hFC);
        write_frame(ADDR_BYTE, 8'hA2, 8'h01, 1'b1);
        step_frame(2'd2, 8'h00, 3);
        check("R7 step down stops at 00", {24'b0, wiper_codes[23:16]}, 32'h00);

        // R8: wiper write and unfinished storage write start no save
        read_frame(8'h50, rv, oe);
        check("R8 no save after wiper write", {24'b0, rv}, 32'h00);
        frame_open();
        send_bits(ADDR_BYTE, 8); send_bits(8'hC0, 8); send_bits(8'hFF, 4);
        frame_close();
        read_frame(8'h50, rv, oe);
        check("R8 no save after partial byte", {24'b0, rv}, 32'h00);
        read_frame(8'hB0, rv, oe);
        check("R8 partial byte not stored", {24'b0, rv}, 32'h00);

        // R8 R9 R10: full storage write, busy status, lockout
        write_frame(ADDR_BYTE, 8'hC0, 8'h11, 1'b1);
        read_frame(8'h50, rv, oe);
        check("R9 status busy bit", {24'b0, rv}, 32'h01);
        write_frame(ADDR_BYTE, 8'hA3, 8'h44, 1'b1);
        check("R10 write ignored while busy", {24'b0, wiper_codes[31:24]}, 32'h77);
        wait_clk(BUSY + 100);
        read_frame(8'h50, rv, oe);
        check("R9 status clear after save", {24'b0, rv}, 32'h00);
        read_frame(8'hB0, rv, oe);
        check("R5 stored byte kept", {24'b0, rv}, 32'h11);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule